// File: doc/BRIEF.md
# SPI Slave Transceiver with Control Register

This block is the slave side of a serial peripheral interface, run from one system clock and set up through a small synchronous register bus. An 8-bit control word sets the role (master or slave), the clock idle level, the clock phase, open-drain pin control, a module enable and two interrupt enables. A CPU writes the byte to send into a transmit holding register. It reads each byte received from a receive data register, which raises a full flag.

The external SCK, SS and MOSI pins are passed through two-flop synchronizers. All edge detection runs in the system clock domain, so SCK must run no faster than one quarter of the system clock. The datapath shifts MSB first. It samples MOSI on the sampling edge that the phase setting picks and updates MISO on the opposite edge. The start of a transfer depends on the phase setting: with phase 0 the falling edge of SS starts it, and with phase 1 the first SCK edge seen while SS is low starts it. Once a transfer is running, the shift register is closed to new transmit data.

Bus map: address 0 is the control word, address 1 is status (bit 7 receive full, bit 3 transmit empty, all other bits 0), and address 2 is data (a write goes to the transmit holding register, a read returns the receive data register).

Top module: `spi_slave_xcvr`

## Requirements
- R1: After reset the control word reads 0x28 (master select and phase bits set), status reads 0x08, both interrupts are low and MISO is not driven.
- R2: Control bit positions are: 7 receive-interrupt enable, 6 reserved (always reads 0), 5 master select, 4 clock polarity, 3 clock phase, 2 open-drain, 1 enable, 0 transmit-interrupt enable. Writing 0xFF reads back 0xBF.
- R3: With phase 0, the falling edge of SS starts a transfer and MISO carries the MSB of the transmit byte before the first SCK edge. Eight bits are exchanged MSB first.
- R4: With phase 1, the first SCK edge while SS is low starts the transfer, and eight bits are exchanged MSB first.
- R5: The polarity bit gives the SCK idle level. In all four polarity and phase combinations the master receives the transmit byte, and the receive register ends up holding the master's byte.
- R6: While SS is high, MISO is not driven, and SCK edges neither start a transfer nor set the receive-full flag.
- R7: A data write during a transfer does not change the byte being shifted out. The written byte is the one sent in the next transfer.
- R8: Receive full sets when a byte completes and clears when data address 2 is read. A byte that completes while the flag is set overwrites the register.
- R9: The receive interrupt is high exactly when receive full and its enable are both 1. The transmit interrupt is high exactly when transmit empty and its enable are both 1. Transmit empty clears on a data write and sets when the holding register is loaded into the shifter.
- R10: With the open-drain bit set, the wired-OR output is 1 and MISO is only ever driven low (enable high with MISO output low), otherwise released.
- R11: With enable 0 or master select 1, no transfer runs and MISO is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (reading data clears receive full) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| sck_i | input | 1 | Serial clock from master |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | MISO output enable |
| wired_or_o | output | 1 | Open-drain mode for SCK, MOSI and MISO pads |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_tx_o | output | 1 | Transmit interrupt request |

## Verification
A wrong bit counter or a missed start shows at the pins within one byte. The master reads a rotated or stale byte on MISO, and receive full rises early, late or not at all, about three system clocks after the eighth sampling edge. A shift register that is wrongly reloaded in mid-byte corrupts the remaining MISO bits of that transfer. A holding register that fails to reload shows up only in the next transfer. Gating faults on SS or the enable show as MISO driven while deselected, or as a receive-full flag set by edges that should have been ignored.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic rx_ie;
    logic rsvd;
    logic master;
    logic cpol;
    logic cpha;
    logic wired_or;
    logic enable;
    logic tx_ie;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST   = 8'h28;
  localparam logic [7:0] CTRL_WMASK = 8'hBF;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_addr_e;

  localparam int STAT_RX_BIT = 7;
  localparam int STAT_TX_BIT = 3;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int            WIDTH  = 3,
  parameter int            STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sck_s_i,
  input  logic              ss_s_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              load_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sel_o,
  output logic              miso_bit_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q, ss_q, busy_q, miso_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic rise, fall, lead, trail, samp_edge, shft_edge, sel, start;

  assign rise      = sck_s_i & ~sck_q;
  assign fall      = ~sck_s_i & sck_q;
  assign lead      = cpol_i ? fall : rise;
  assign trail     = cpol_i ? rise : fall;
  assign samp_edge = cpha_i ? trail : lead;
  assign shft_edge = cpha_i ? lead : trail;
  assign sel       = en_i & ~ss_s_i;
  // phase 0: SS falling edge; phase 1: first leading SCK edge when idle
  assign start     = sel & (cpha_i ? (lead & ~busy_q) : ss_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      ss_q  <= ss_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      miso_q  <= 1'b0;
    end else if (start) begin
      shreg_q <= tx_i;
      miso_q  <= tx_i[DATA_W-1];
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (sel && busy_q) begin
      if (samp_edge) begin
        shreg_q <= {shreg_q[DATA_W-2:0], mosi_s_i};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end
      if (shft_edge) miso_q <= shreg_q[DATA_W-1];
    end
  end

  assign load_o     = start;
  assign done_o     = sel & busy_q & samp_edge & (cnt_q == LAST) & ~start;
  assign rx_o       = {shreg_q[DATA_W-2:0], mosi_s_i};
  assign sel_o      = sel;
  assign miso_bit_o = miso_q;

  // R6: deselected slave keeps its transfer state
  p_ss_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_s_i |=> ($stable(shreg_q) && $stable(busy_q) && $stable(miso_q)));
  // R7: a running transfer only changes its shift register on sampling edges
  p_tx_lockout_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !samp_edge && !start) |=> $stable(shreg_q));
endmodule

// File: rtl/spi_slave_regs.sv
module spi_slave_regs
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              load_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              tx_empty_q, rx_full_q;
  logic              wr_ctrl, wr_data, rd_data;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_data = wr_en_i && (addr_i == ADDR_W'(REG_DATA));
  assign rd_data = rd_en_i && (addr_i == ADDR_W'(REG_DATA));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[7:0] & CTRL_WMASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q       <= '0;
      tx_empty_q <= 1'b1;
    end else if (wr_data) begin
      tx_q       <= wdata_i;
      tx_empty_q <= 1'b0;
    end else if (load_i) begin
      tx_empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_full_q <= 1'b0;
    end else if (done_i) begin
      rx_q      <= rx_word_i;
      rx_full_q <= 1'b1;
    end else if (rd_data) begin
      rx_full_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(REG_CTRL): rdata_o[7:0] = ctrl_q;
      ADDR_W'(REG_STAT): begin
        rdata_o[STAT_RX_BIT] = rx_full_q;
        rdata_o[STAT_TX_BIT] = tx_empty_q;
      end
      ADDR_W'(REG_DATA): rdata_o = rx_q;
      default:           rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign tx_word_o = tx_q;
  assign irq_rx_o  = rx_full_q & ctrl_q.rx_ie;
  assign irq_tx_o  = tx_empty_q & ctrl_q.tx_ie;

  // R8: receive full only rises from a completed byte
  p_rx_set_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_q) |-> $past(done_i));
  // R8: a data read without a completing byte empties the flag
  p_rx_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !done_i) |=> !rx_full_q);
  // R9: a data write leaves the holding register full
  p_tx_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> !tx_empty_q);
endmodule

// File: rtl/spi_slave_xcvr.sv
module spi_slave_xcvr
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              wired_or_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic [2:0]        pins_s;
  logic              load, done, sel, miso_bit;

  // bit order: {mosi, ss, sck}; SS idles high
  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({mosi_i, ss_ni, sck_i}),
    .q_o (pins_s)
  );

  spi_slave_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o,
    .load_i    (load),
    .done_i    (done),
    .rx_word_i (rx_word),
    .ctrl_o    (ctrl),
    .tx_word_o (tx_word),
    .irq_rx_o, .irq_tx_o
  );

  spi_slave_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .en_i       (ctrl.enable & ~ctrl.master),
    .cpol_i     (ctrl.cpol),
    .cpha_i     (ctrl.cpha),
    .sck_s_i    (pins_s[0]),
    .ss_s_i     (pins_s[1]),
    .mosi_s_i   (pins_s[2]),
    .tx_i       (tx_word),
    .load_o     (load),
    .done_o     (done),
    .rx_o       (rx_word),
    .sel_o      (sel),
    .miso_bit_o (miso_bit)
  );

  assign wired_or_o = ctrl.wired_or;
  assign miso_o     = ctrl.wired_or ? 1'b0 : miso_bit;
  assign miso_oe_o  = sel & (ctrl.wired_or ? ~miso_bit : 1'b1);

  // R6: deselected slave releases MISO
  p_miso_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s[1] |-> !miso_oe_o);
endmodule

// File: tb/spi_slave_xcvr_bench.sv
module spi_slave_xcvr_bench;
  localparam int HALF = 5;

  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic       sck = 0, ss_n = 1, mosi = 0;
  logic       miso, miso_oe, wired_or, irq_rx, irq_tx;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_slave_xcvr u_spi_slave_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .sck_i(sck), .ss_ni(ss_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .wired_or_o(wired_or),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx)
  );

  function automatic logic [7:0] ctrl_word(logic rie, logic mst, logic cpol, logic cpha,
                                           logic wo, logic en, logic tie);
    return {rie, 1'b0, mst, cpol, cpha, wo, en, tie};
  endfunction

  function automatic logic [7:0] stat_word(logic rxf, logic txe);
    return {rxf, 3'b000, txe, 3'b000};
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // one master-side byte exchange; optional data write in mid-transfer
  task automatic xfer(logic cpol, logic cpha, logic [7:0] m, output logic [7:0] s,
                      input bit mid_wr, input logic [7:0] mid_val,
                      output bit od_bad, output bit oe_seen);
    logic line;
    od_bad = 0; oe_seen = 0; s = 0;
    sck = cpol;
    ss_n = 0;
    for (int i = 7; i >= 0; i--) begin
      if (cpha) sck = ~cpol;
      mosi = m[i];
      for (int c = 0; c < HALF; c++) begin
        if (mid_wr && i == 4 && c == 0) bus_wr(2'd2, mid_val);
        else @(negedge clk);
        if (miso_oe) oe_seen = 1;
        if (wired_or && miso_oe && miso) od_bad = 1;
      end
      line = miso_oe ? miso : 1'b1;
      s[i] = line;
      sck = cpha ? cpol : ~cpol;
      wait_clk(HALF);
      if (!cpha) sck = cpol;
    end
    wait_clk(HALF);
    ss_n = 1;
    wait_clk(HALF);
  endtask

  task automatic setup(logic [7:0] c, logic cpol);
    bus_wr(2'd0, c);
    sck = cpol;
    wait_clk(6);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r, s, t, m, c;
    bit od, oe;
    logic cpol, cpha, wo;
    void'($urandom(32'h5EED_0042));
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);

    bus_rd(2'd0, r); chk(r == 8'h28, "R1 ctrl reset", r, 8'h28);
    bus_rd(2'd1, r); chk(r == stat_word(0, 1), "R1 status reset", r, stat_word(0, 1));
    chk({irq_rx, irq_tx, miso_oe} == 3'b000, "R1 irq/oe reset", {5'b0, irq_rx, irq_tx, miso_oe}, 8'h00);

    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, r); chk(r == 8'hBF, "R2 reserved bit reads 0", r, 8'hBF);
    chk(wired_or == 1'b1, "R10 wired-or pin", {7'b0, wired_or}, 8'h01);

    // R3 directed: phase 0, polarity 0
    setup(ctrl_word(0, 0, 0, 0, 0, 1, 0), 0);
    bus_wr(2'd2, 8'hA5);
    xfer(0, 0, 8'h3C, s, 0, 0, od, oe);
    chk(s == 8'hA5, "R3 MISO byte", s, 8'hA5);
    bus_rd(2'd1, r); chk(r[7] == 1'b1, "R8 rx full set", r, stat_word(1, 1));
    bus_rd(2'd2, r); chk(r == 8'h3C, "R3 rx byte", r, 8'h3C);
    bus_rd(2'd1, r); chk(r[7] == 1'b0, "R8 rx full cleared", r, stat_word(0, 1));

    // R4 directed: phase 1, polarity 1
    setup(ctrl_word(0, 0, 1, 1, 0, 1, 0), 1);
    bus_wr(2'd2, 8'h96);
    xfer(1, 1, 8'hC3, s, 0, 0, od, oe);
    chk(s == 8'h96, "R4 MISO byte", s, 8'h96);
    bus_rd(2'd2, r); chk(r == 8'hC3, "R4 rx byte", r, 8'hC3);

    // R5 / R10 random modes
    for (int k = 0; k < 24; k++) begin
      cpol = 1'($urandom); cpha = 1'($urandom); wo = 1'($urandom);
      t = 8'($urandom); m = 8'($urandom);
      if (k < 4) begin cpol = k[0]; cpha = k[1]; end
      setup(ctrl_word(0, 0, cpol, cpha, wo, 1, 0), cpol);
      bus_wr(2'd2, t);
      xfer(cpol, cpha, m, s, 0, 0, od, oe);
      chk(s == t, cpha ? "R5 R4 random MISO" : "R5 R3 random MISO", s, t);
      bus_rd(2'd2, r); chk(r == m, "R5 random rx", r, m);
      chk(!od, "R10 open-drain drives only low", {7'b0, od}, 8'h00);
    end

    // R7 lockout
    setup(ctrl_word(0, 0, 0, 1, 0, 1, 0), 0);
    bus_wr(2'd2, 8'h81);
    xfer(0, 1, 8'h00, s, 1, 8'h7E, od, oe);
    chk(s == 8'h81, "R7 byte in flight kept", s, 8'h81);
    xfer(0, 1, 8'h00, s, 0, 0, od, oe);
    chk(s == 8'h7E, "R7 held byte sent next", s, 8'h7E);
    bus_rd(2'd2, r);

    // R9 interrupts
    setup(ctrl_word(1, 0, 0, 0, 0, 1, 1), 0);
    chk(irq_tx == 1'b1, "R9 irq_tx empty", {7'b0, irq_tx}, 8'h01);
    bus_wr(2'd2, 8'h5A);
    chk(irq_tx == 1'b0, "R9 irq_tx after write", {7'b0, irq_tx}, 8'h00);
    chk(irq_rx == 1'b0, "R9 irq_rx idle", {7'b0, irq_rx}, 8'h00);
    xfer(0, 0, 8'h11, s, 0, 0, od, oe);
    chk(irq_tx == 1'b1, "R9 irq_tx after load", {7'b0, irq_tx}, 8'h01);
    chk(irq_rx == 1'b1, "R9 irq_rx after byte", {7'b0, irq_rx}, 8'h01);
    bus_rd(2'd2, r);
    chk(irq_rx == 1'b0, "R9 irq_rx after read", {7'b0, irq_rx}, 8'h00);

    // R8 overwrite
    xfer(0, 0, 8'h22, s, 0, 0, od, oe);
    xfer(0, 0, 8'hE7, s, 0, 0, od, oe);
    bus_rd(2'd2, r); chk(r == 8'hE7, "R8 overwrite", r, 8'hE7);

    // R6 SS high: edges ignored
    setup(ctrl_word(0, 0, 0, 1, 0, 1, 0), 0);
    oe = 0;
    for (int e = 0; e < 16; e++) begin
      sck = ~sck; mosi = 1'($urandom);
      for (int c2 = 0; c2 < HALF; c2++) begin
        @(negedge clk);
        if (miso_oe) oe = 1;
      end
    end
    sck = 0; wait_clk(6);
    chk(!oe, "R6 MISO released", {7'b0, oe}, 8'h00);
    bus_rd(2'd1, r); chk(r[7] == 1'b0, "R6 no rx", r, 8'h00);
    bus_wr(2'd2, 8'h3D);
    xfer(0, 1, 8'h4B, s, 0, 0, od, oe);
    chk(s == 8'h3D, "R6 state intact after deselect", s, 8'h3D);
    bus_rd(2'd2, r); chk(r == 8'h4B, "R6 rx after deselect", r, 8'h4B);

    // R11 inactive: master role, then disabled
    for (int v = 0; v < 2; v++) begin
      c = (v == 0) ? ctrl_word(0, 1, 0, 0, 0, 1, 0) : ctrl_word(0, 0, 0, 0, 0, 0, 0);
      setup(c, 0);
      xfer(0, 0, 8'h99, s, 0, 0, od, oe);
      chk(!oe, "R11 MISO not driven", {7'b0, oe}, 8'h00);
      bus_rd(2'd1, r); chk(r[7] == 1'b0, "R11 no rx", r, 8'h00);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule